// File: doc/BRIEF.md
# Page Write Buffer with In-Page Wrap

This block gathers the data bytes of one serial write session and later stores them into a byte-wide memory array in a single commit. A session opens with a start strobe and a byte address. The upper address bits pick the page, and that page stays fixed for the whole session. The lower bits give the first in-page offset. Each data strobe stores one byte at the current offset and then steps the offset forward. Past the last slot of the page, the offset wraps to slot 0 of the same page, so a long stream overwrites bytes it loaded earlier.

A commit request (the STOP of the serial session) hands the session to a sequencer. The sequencer walks the page slots in ascending order and writes to the array only the slots that received a byte. It then waits out a fixed internal write time, and only after that does it release the busy flag. An abort, or a commit with no data bytes, throws the session away and writes nothing. The array is modelled as a register memory that resets to the erased value FFh. A combinational read port lets the surrounding logic observe its contents.

Top module: `page_write_buf`

## Requirements
- R1: After reset, every array byte reads FFh, busy_o is low and arr_we_o is low.
- R2: A start strobe opens a session. It latches the page as addr_i[ADDR_W-1:4] and the first offset as addr_i[3:0]. The first data byte lands at exactly addr_i.
- R3: Each accepted data byte advances the offset by one. After offset 15 the offset returns to offset 0 of the same page, and it never reaches a neighbouring page.
- R4: A byte loaded into an offset that already holds a byte from the current session replaces it. Only the latest value reaches the array.
- R5: A commit writes only the offsets that received bytes in the session. All other array bytes, in the same page and elsewhere, keep their previous values.
- R6: An abort discards the session, and nothing is written. A commit on a session with no data bytes writes nothing, and busy_o stays low.
- R7: For an accepted commit with at least one byte, busy_o rises in the cycle after the commit request. It stays high for exactly PAGE_BYTES + TWR_CYCLES cycles.
- R8: While busy_o is high, the start, data, commit and abort inputs are ignored.
- R9: arr_we_o is asserted only while busy_o is high. Successive write strobes of one commit use strictly ascending addresses within one page.
- R10: Data strobes and commit requests outside an open session are ignored.
- R11: When strobes coincide in one cycle of an open session, abort wins over commit, commit wins over start, and start wins over a data byte. A start during an open session restarts it with an empty buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Open a session at addr_i |
| addr_i | input | ADDR_W | Start byte address of the session |
| byte_valid_i | input | 1 | Data byte strobe |
| byte_i | input | DATA_W | Data byte |
| commit_i | input | 1 | Commit request (end of session) |
| abort_i | input | 1 | Discard the session |
| busy_o | output | 1 | Commit sequence in progress |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | DATA_W | Array read data (combinational) |

## Verification
Directed sessions cover three cases. A start address at the end of the address space shows whether the page and offset are latched correctly. A start near the end of a page tells in-page wrap apart from a carry into the next page. A stream longer than a page shows whether replaced bytes or earlier bytes reach the array. Randomly sized sessions, some aborted and some empty, test that only touched slots change and that the busy length is fixed. Noise driven during busy and strobes driven outside any session must leave both the array and the busy timing unchanged. Same-cycle strobe collisions settle the priority order.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_SCAN = 2'd2,
    ST_WAIT = 2'd3
  } pwb_state_e;
endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  open_i,
  input  logic [OFF_W-1:0]      open_off_i,
  input  logic                  wr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  clear_i,
  input  logic [OFF_W-1:0]      rd_idx_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic [PAGE_BYTES-1:0] valid_o
);
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] slot_q [PAGE_BYTES];

  // offset wraps inside the page by natural overflow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      off_q <= '0;
    else if (open_i)  off_q <= open_off_i;
    else if (wr_i)    off_q <= off_q + 1'b1;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_i && (off_q == OFF_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                valid_o[g] <= 1'b0;
      else if (clear_i || open_i) valid_o[g] <= 1'b0;
      else if (hit)               valid_o[g] <= 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  slot_q[g] <= '0;
      else if (hit) slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/pwb_commit_ctrl.sv
module pwb_commit_ctrl
  import pwb_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int TWR_CYCLES = 40,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int CNT_W     = $clog2(TWR_CYCLES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  byte_i,
  input  logic                  commit_i,
  input  logic                  abort_i,
  input  logic [PAGE_BYTES-1:0] valid_i,
  output logic                  open_o,
  output logic                  wr_o,
  output logic                  clear_o,
  output logic [OFF_W-1:0]      slot_o,
  output logic                  we_o,
  output logic                  busy_o,
  output logic                  sess_o
);
  localparam logic [OFF_W-1:0] LAST_SLOT = OFF_W'(PAGE_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(TWR_CYCLES - 1);

  pwb_state_e       state_q, state_d;
  logic [OFF_W-1:0] slot_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    open_o  = 1'b0;
    wr_o    = 1'b0;
    clear_o = 1'b0;
    we_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          open_o  = 1'b1;
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (abort_i) begin
          clear_o = 1'b1;
          state_d = ST_IDLE;
        end else if (commit_i) begin
          if (|valid_i) begin
            state_d = ST_SCAN;
          end else begin
            clear_o = 1'b1;
            state_d = ST_IDLE;
          end
        end else if (start_i) begin
          open_o = 1'b1;
        end else if (byte_i) begin
          wr_o = 1'b1;
        end
      end
      ST_SCAN: begin
        we_o = valid_i[slot_q];
        if (slot_q == LAST_SLOT) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (cnt_q == LAST_CNT) begin
          clear_o = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= (state_q == ST_SCAN) ? slot_q + 1'b1 : '0;
      cnt_q   <= (state_q == ST_WAIT) ? cnt_q + 1'b1 : '0;
    end
  end

  assign slot_o = slot_q;
  assign busy_o = (state_q == ST_SCAN) || (state_q == ST_WAIT);
  assign sess_o = (state_q == ST_LOAD);
endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
  parameter int ADDR_W            = 9,
  parameter int DATA_W            = 8,
  parameter logic [DATA_W-1:0] ERASED = '1,
  localparam int DEPTH            = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/page_write_buf.sv
module page_write_buf #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int TWR_CYCLES = 40,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              commit_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic                  open_w, wr_w, clear_w, sess_w;
  logic [OFF_W-1:0]      slot_w;
  logic [PAGE_BYTES-1:0] valid_w;
  logic [PAGE_W-1:0]     page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     page_q <= '0;
    else if (open_w) page_q <= addr_i[ADDR_W-1:OFF_W];
  end

  pwb_commit_ctrl #(
    .PAGE_BYTES(PAGE_BYTES),
    .TWR_CYCLES(TWR_CYCLES)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .byte_i  (byte_valid_i),
    .commit_i(commit_i),
    .abort_i (abort_i),
    .valid_i (valid_w),
    .open_o  (open_w),
    .wr_o    (wr_w),
    .clear_o (clear_w),
    .slot_o  (slot_w),
    .we_o    (arr_we_o),
    .busy_o  (busy_o),
    .sess_o  (sess_w)
  );

  pwb_page_buf #(
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .open_i    (open_w),
    .open_off_i(addr_i[OFF_W-1:0]),
    .wr_i      (wr_w),
    .wr_data_i (byte_i),
    .clear_i   (clear_w),
    .rd_idx_i  (slot_w),
    .rd_data_o (arr_data_o),
    .valid_o   (valid_w)
  );

  assign arr_addr_o = {page_q, slot_w};

  pwb_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (arr_we_o),
    .waddr_i(arr_addr_o),
    .wdata_i(arr_data_o),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/page_write_buf_chk.sv
module page_write_buf_chk #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  parameter int PAGE_W     = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  commit_i,
  input logic                  abort_i,
  input logic                  busy_o,
  input logic                  arr_we_o,
  input logic [ADDR_W-1:0]     arr_addr_o,
  input logic                  sess_i,
  input logic [PAGE_BYTES-1:0] valid_i,
  input logic [PAGE_W-1:0]     page_i
);
  p_we_only_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o);

  p_addr_ascend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o && $past(arr_we_o) |-> arr_addr_o == ADDR_W'($past(arr_addr_o) + 1'b1));

  p_busy_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sess_i && commit_i && !abort_i && (|valid_i) |=> busy_o);

  p_abort_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sess_i && abort_i |=> (valid_i == '0) && !busy_o);

  p_empty_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sess_i && commit_i && (valid_i == '0) |=> !busy_o);

  p_busy_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(valid_i) && $stable(page_i));

  p_idle_clean_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !sess_i |-> valid_i == '0);
endmodule

bind page_write_buf page_write_buf_chk #(
  .ADDR_W    (ADDR_W),
  .PAGE_BYTES(PAGE_BYTES),
  .PAGE_W    (PAGE_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .commit_i  (commit_i),
  .abort_i   (abort_i),
  .busy_o    (busy_o),
  .arr_we_o  (arr_we_o),
  .arr_addr_o(arr_addr_o),
  .sess_i    (sess_w),
  .valid_i   (valid_w),
  .page_i    (page_q)
);

// File: tb/page_write_buf_bench.sv
module page_write_buf_bench;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;
  localparam int PAGE   = 16;
  localparam int TWR    = 40;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              byte_valid_i = 1'b0;
  logic [DATA_W-1:0] byte_i = '0;
  logic              commit_i = 1'b0;
  logic              abort_i = 1'b0;
  logic              busy_o, arr_we_o;
  logic [ADDR_W-1:0] arr_addr_o;
  logic [DATA_W-1:0] arr_data_o;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [DATA_W-1:0] rd_data_o;

  int checks = 0;
  int errors = 0;

  logic [DATA_W-1:0] m_mem [DEPTH];
  logic [DATA_W-1:0] m_buf [PAGE];
  logic              m_vld [PAGE];
  logic [4:0]        m_page;
  logic [3:0]        m_off;
  logic              m_sess;

  always #(CLK_P/2) clk_i = ~clk_i;

  page_write_buf #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE), .TWR_CYCLES(TWR)
  ) u_page_write_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i), .commit_i(commit_i),
    .abort_i(abort_i), .busy_o(busy_o), .arr_we_o(arr_we_o),
    .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  function automatic int exp_busy_len();
    return PAGE + TWR;
  endfunction

  function automatic bit model_any();
    for (int i = 0; i < PAGE; i++) if (m_vld[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    int bad = 0, fa = 0, fact = 0, fexp = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr_i = ADDR_W'(a);
      #1;
      if (rd_data_o !== m_mem[a]) begin
        if (bad == 0) begin fa = a; fact = rd_data_o; fexp = m_mem[a]; end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: addr %0d actual %0d expected %0d (%0d mismatches)",
               req, fa, fact, fexp, bad);
    end
    @(negedge clk_i);
  endtask

  // all drive tasks enter and leave at a falling edge
  task automatic do_start(input logic [ADDR_W-1:0] a);
    start_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    start_i = 1'b0;
    m_sess = 1'b1; m_page = a[ADDR_W-1:4]; m_off = a[3:0];
    for (int i = 0; i < PAGE; i++) m_vld[i] = 1'b0;
  endtask

  task automatic model_byte(input logic [DATA_W-1:0] b);
    if (m_sess) begin
      m_buf[m_off] = b; m_vld[m_off] = 1'b1; m_off = m_off + 1'b1;
    end
  endtask

  task automatic do_byte(input logic [DATA_W-1:0] b);
    byte_valid_i = 1'b1; byte_i = b;
    @(negedge clk_i);
    byte_valid_i = 1'b0;
    model_byte(b);
  endtask

  task automatic do_abort();
    abort_i = 1'b1;
    @(negedge clk_i);
    abort_i = 1'b0;
    m_sess = 1'b0;
    for (int i = 0; i < PAGE; i++) m_vld[i] = 1'b0;
  endtask

  // commit, measure busy, optionally drive noise during busy (R8)
  task automatic do_commit(input bit noise, input string req);
    int cnt = 0;
    int exp;
    exp = (m_sess && model_any()) ? exp_busy_len() : 0;
    if (exp != 0)
      for (int i = 0; i < PAGE; i++)
        if (m_vld[i]) m_mem[{m_page, 4'(i)}] = m_buf[i];
    m_sess = 1'b0;
    for (int i = 0; i < PAGE; i++) m_vld[i] = 1'b0;
    commit_i = 1'b1;
    @(negedge clk_i);
    commit_i = 1'b0;
    while (busy_o && cnt < 4 * exp_busy_len()) begin
      cnt++;
      if (noise) begin
        start_i = $urandom_range(0, 1); addr_i = ADDR_W'($urandom);
        byte_valid_i = $urandom_range(0, 1); byte_i = DATA_W'($urandom);
        commit_i = $urandom_range(0, 1); abort_i = $urandom_range(0, 1);
      end
      @(negedge clk_i);
    end
    start_i = 1'b0; byte_valid_i = 1'b0; commit_i = 1'b0; abort_i = 1'b0;
    check(cnt == exp, req, cnt, exp);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < DEPTH; a++) m_mem[a] = 8'hFF;
    for (int i = 0; i < PAGE; i++) begin m_vld[i] = 1'b0; m_buf[i] = '0; end
    m_sess = 1'b0; m_page = '0; m_off = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check(busy_o == 1'b0, "R1 busy", busy_o, 0);
    check(arr_we_o == 1'b0, "R1 we", arr_we_o, 0);
    compare_all("R1 erased");

    // R2 latch page/offset at top of address space
    do_start(9'h1F3);
    do_byte(8'h11); do_byte(8'h22); do_byte(8'h33);
    do_commit(1'b0, "R7 busy length");
    compare_all("R2 start address");

    // R3 wrap inside page 0, never into page 1
    do_start(9'h00E);
    for (int i = 0; i < 4; i++) do_byte(8'hA0 + 8'(i));
    do_commit(1'b0, "R7 busy length");
    compare_all("R3 in-page wrap");

    // R4 stream longer than a page, later bytes replace
    do_start(9'h040);
    for (int i = 0; i < 20; i++) do_byte(8'(i + 1));
    do_commit(1'b1, "R8 busy under noise");
    compare_all("R4 R8 overwrite and ignore while busy");

    // R5 sparse page write keeps untouched bytes
    do_start(9'h045);
    do_byte(8'h5A);
    do_commit(1'b0, "R7 busy length");
    compare_all("R5 partial page");

    // R6 abort and empty commit
    do_start(9'h100);
    do_byte(8'h77); do_byte(8'h78);
    do_abort();
    do_commit(1'b0, "R6 commit after abort");
    do_start(9'h120);
    do_commit(1'b0, "R6 empty commit");
    compare_all("R6 nothing written");

    // R10 strobes without a session
    do_byte(8'h99);
    do_commit(1'b0, "R10 commit without session");
    compare_all("R10 no session");

    // R11 abort beats commit in one cycle
    do_start(9'h150);
    do_byte(8'h12);
    abort_i = 1'b1; commit_i = 1'b1;
    @(negedge clk_i);
    abort_i = 1'b0; commit_i = 1'b0;
    m_sess = 1'b0; m_vld[0] = 1'b0;
    check(busy_o == 1'b0, "R11 abort over commit", busy_o, 0);
    // R11 commit beats byte
    do_start(9'h160);
    do_byte(8'h34);
    byte_valid_i = 1'b1; byte_i = 8'h56;
    do_commit(1'b0, "R11 commit over byte");
    // R11 start restarts and beats byte
    do_start(9'h170);
    do_byte(8'h41);
    byte_valid_i = 1'b1; byte_i = 8'h42;
    do_start(9'h178);
    do_byte(8'h43);
    do_commit(1'b0, "R11 restart");
    compare_all("R11 priority");

    // random sessions
    for (int s = 0; s < 30; s++) begin
      int n;
      bit abt;
      n = $urandom_range(0, 40);
      abt = ($urandom_range(0, 5) == 0);
      do_start(ADDR_W'($urandom));
      for (int k = 0; k < n; k++) do_byte(DATA_W'($urandom));
      if (abt) do_abort();
      do_commit(s % 3 == 0, "R7 R8 random busy");
      if (s % 5 == 4) compare_all("R5 random sessions");
    end
    compare_all("R3 R4 R5 random final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule